// File: doc/BRIEF.md
# Synchronous SRAM with Pipelined Reads and Two-Cycle Deferred Writes

This block models a single-port synchronous SRAM whose data bus serves reads and writes in strict command order. A command (address, chip enable, write enable, lane enables) is captured on a rising clock edge. Read data is driven onto the shared bus one cycle later. Write data is taken from the same bus two edges after its command. Because both kinds of transfer occupy the bus in the same relative slot, reads and writes can alternate every cycle without idle turnaround cycles.

The word is split into byte lanes, each with its own active-low write enable. A write with no lane enabled is a write abort: it uses its bus slot and leaves the array untouched. Writes whose data has not yet reached the array are held in a two-stage pipeline. A read of an address that has a write landing in the same edge returns the merged word, built from the enabled lanes of the incoming data and the array for the rest. An advance input lets a command reuse the previous command address plus one instead of the address bus. An output-enable input gates the read driver, and a strobe output marks the cycles in which the block drives the bus.

Top module: `dlw_sram`

## Requirements
- R1: A write command captured at edge n takes its data from `dq` at edge n+2; the write data is driven by the host in the cycle between edges n+1 and n+2.
- R2: A read command captured at edge n drives the addressed word on `dq` from just after edge n+1 until edge n+2 while `oe_n` is low.
- R3: Read and write commands may alternate on consecutive edges; the block never drives `dq` in a cycle that carries write data, and every transfer returns or stores the correct word.
- R4: A command with `we_n` high is a read, and `bw_n` has no effect on it.
- R5: Lane i (bits 9*i+8 down to 9*i, lane 0 holding bit 0) is written only when `bw_n[i]` was low with the write command; other lanes keep their stored values.
- R6: A write with all four `bw_n` bits high (abort) completes its bus slot and leaves the array unchanged.
- R7: The lane mask applied is the one captured with the write command, not the `bw_n` value present when the data arrives.
- R8: A read issued on the edge after a write to the same address returns the enabled lanes of that write data merged with the stored remaining lanes.
- R9: With `ce_n` high no command is issued; once earlier reads have drained, `dq` is high impedance and `dvalid` is low.
- R10: `dvalid` is high exactly in the cycles in which the block drives `dq`; with `oe_n` high the block does not drive the bus even in a read data slot.
- R11: With `adv` high the command address is the previous command address plus one, modulo the depth, and `addr` is ignored; with `adv` low `addr` is loaded.
- R12: After reset the pipeline is empty: `dvalid` is low and `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the command pipeline |
| ce_n | input | 1 | Active-low chip enable; high means deselect |
| we_n | input | 1 | Active-low write enable; high means read |
| adv | input | 1 | High: use previous address plus one; low: load `addr` |
| oe_n | input | 1 | Active-low output enable of the read driver |
| addr | input | AW (4) | Word address |
| bw_n | input | LANES (4) | Active-low per-lane write enables |
| dq | inout | LANES*LANE_W (36) | Shared data bus |
| dvalid | output | 1 | High while the block drives read data on `dq` |

## Verification
The case where a write's data lands in the array on the very edge that registers a read of the same address is the one where two functions meet in one cycle: the array update and the read data capture. It is provoked by issuing a partial-lane write immediately followed by a read of the same address, so that the read must take the enabled lanes straight from the bus and the others from the array. The result is judged against a bench array that applies each write in the cycle its data is driven, and the same pattern is repeated inside back-to-back alternating sequences and with an abort in place of the write.

// File: rtl/dlw_sram.sv
module dlw_sram #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    adv,
  input  logic                    oe_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES-1:0]        bw_n,
  inout  wire  [LANES*LANE_W-1:0] dq,
  output logic                    dvalid
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    last_a, cmd_a;
  logic             s1_v, s1_w, s2_v, s2_w, rd_v;
  logic [AW-1:0]    s1_a, s2_a;
  logic [LANES-1:0] s1_m, s2_m;
  logic [DW-1:0]    rd_q, fwd;
  logic             wr_now, hit;

  assign cmd_a  = adv ? last_a + 1'b1 : addr;
  assign wr_now = s2_v && s2_w;
  assign hit    = wr_now && (s2_a == s1_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_w <= 1'b0; s1_a <= '0; s1_m <= '0;
      s2_v <= 1'b0; s2_w <= 1'b0; s2_a <= '0; s2_m <= '0;
      rd_v <= 1'b0; rd_q <= '0;   last_a <= '0;
    end else begin
      s1_v <= !ce_n;
      s1_w <= !we_n;
      s1_a <= cmd_a;
      s1_m <= ~bw_n;
      if (!ce_n) last_a <= cmd_a;
      s2_v <= s1_v;
      s2_w <= s1_w;
      s2_a <= s1_a;
      s2_m <= s1_m;
      rd_v <= s1_v && !s1_w;
      if (s1_v && !s1_w) rd_q <= fwd;
    end
  end

  always_comb begin
    fwd = mem[s1_a];
    for (int i = 0; i < LANES; i++)
      if (hit && s2_m[i]) fwd[i*LANE_W +: LANE_W] = dq[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wr_now && s2_m[i]) mem[s2_a][i*LANE_W +: LANE_W] <= dq[i*LANE_W +: LANE_W];
  end

  assign dvalid = rd_v && !oe_n;
  assign dq     = dvalid ? rd_q : {DW{1'bz}};

  AST_RD_SLOT:    assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n) |-> ##2 (dvalid || oe_n)); // R2
  AST_WR_NO_DRV:  assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> ##2 !dvalid); // R3
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> ##2 !dvalid); // R9
  AST_OE_GATE:    assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dvalid); // R10
endmodule

// File: tb/dlw_sram_test.sv
`timescale 1ns/1ps
module dlw_sram_test;
  localparam int DEPTH = 16;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, adv = 0, oe_n = 0;
  logic [3:0] addr = '0, bw_n = '1;
  wire  [35:0] dq;
  logic [35:0] tb_dq = '0;
  logic tb_drv = 0;
  logic dvalid;
  int total = 0, fails = 0;

  logic [35:0] refm [DEPTH];
  logic h_v [2], h_w [2];
  int h_a [2];
  logic [3:0] h_m [2];
  logic [35:0] h_d [2];
  string h_t [2];
  int last_a = 0;

  assign dq = tb_drv ? tb_dq : 36'bz;
  always #2.5 clk = ~clk;

  dlw_sram uut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .adv(adv),
                .oe_n(oe_n), .addr(addr), .bw_n(bw_n), .dq(dq), .dvalid(dvalid));

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: command for this cycle, plus data/check for the command two cycles back.
  task automatic step(input bit ce, input bit wr, input bit ad, input logic [3:0] bwn,
                      input int a, input logic [35:0] wd, input bit oe, input string tag);
    int ra;
    tb_drv = 0;
    if (h_v[1] && h_w[1]) begin
      tb_dq = h_d[1]; tb_drv = 1;
      for (int i = 0; i < 4; i++)
        if (h_m[1][i]) refm[h_a[1]][i*9 +: 9] = h_d[1][i*9 +: 9];
    end
    ra = ad ? (last_a + 1) % DEPTH : a;
    ce_n = !ce; we_n = !wr; adv = ad; bw_n = bwn; addr = 4'(a); oe_n = !oe;
    #1;
    if (h_v[1] && !h_w[1]) begin
      if (oe) begin
        chk(h_t[1], dq, refm[h_a[1]]);
        chk("R10 dvalid in read slot", {35'b0, dvalid}, 36'd1);
      end else begin
        chk("R10 bus released with oe_n high", dq, 36'bz);
        chk("R10 dvalid with oe_n high", {35'b0, dvalid}, 36'd0);
      end
    end else
      chk("R10 dvalid outside read slot", {35'b0, dvalid}, 36'd0);
    h_v[1] = h_v[0]; h_w[1] = h_w[0]; h_a[1] = h_a[0]; h_m[1] = h_m[0];
    h_d[1] = h_d[0]; h_t[1] = h_t[0];
    h_v[0] = ce; h_w[0] = wr; h_a[0] = ra; h_m[0] = ~bwn; h_d[0] = wd; h_t[0] = tag;
    if (ce) last_a = ra;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [3:0] bwn, input logic [35:0] d);
    step(1, 1, 0, bwn, a, d, 1, "write");
  endtask
  task automatic rd(input int a, input logic [3:0] bwn, input string tag);
    step(1, 0, 0, bwn, a, '0, 1, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 4'hf, 0, '0, 1, "idle");
  endtask

  task automatic t_reset;
    chk("R12 dvalid after reset", {35'b0, dvalid}, 36'd0);
    chk("R12 bus after reset", dq, 36'bz);
  endtask

  task automatic t_full;
    wr(3, 4'h0, 36'h1_2345_6789);
    wr(4, 4'h0, 36'hA_BCDE_F012);
    idle(2);
    rd(3, 4'h0, "R1 full word written two edges later");
    rd(4, 4'h5, "R4 read ignores bw_n");
    idle(2);
  endtask

  task automatic t_lanes;
    wr(5, 4'h0, 36'h0_0000_0000);
    wr(5, 4'he, 36'hF_FFFF_FFFF);
    wr(5, 4'h7, 36'h5_5555_5555);
    idle(2);
    rd(5, 4'h0, "R5 per-lane write enables");
    idle(2);
  endtask

  task automatic t_abort;
    wr(5, 4'hf, 36'h0_1234_5678);
    idle(2);
    rd(5, 4'hf, "R6 abort leaves word unchanged");
    wr(9, 4'h0, 36'h3_3333_3333);
    wr(9, 4'hf, 36'hC_CCCC_CCCC);
    rd(9, 4'h0, "R6 abort then read, no change");
    idle(2);
  endtask

  task automatic t_mask;
    wr(6, 4'h0, 36'h0_0000_0000);
    idle(2);
    wr(6, 4'hb, 36'h9_8765_4321);
    wr(7, 4'h0, 36'h1_1111_1111);
    rd(6, 4'h0, "R7 mask captured with command");
    idle(2);
  endtask

  task automatic t_interleave;
    wr(10, 4'h0, 36'h0_AAAA_0001);
    wr(11, 4'h0, 36'h0_BBBB_0002);
    idle(2);
    rd(10, 4'h0, "R3 alternating read");
    wr(12, 4'h0, 36'h0_CCCC_0003);
    rd(11, 4'h0, "R3 alternating read");
    wr(13, 4'h3, 36'h0_DDDD_0004);
    rd(12, 4'h0, "R3 read after interleaved write");
    wr(10, 4'hc, 36'hF_0000_FFFF);
    rd(10, 4'h0, "R3 interleaved forward");
    idle(2);
  endtask

  task automatic t_forward;
    wr(8, 4'h0, 36'h1_2121_2121);
    idle(2);
    wr(8, 4'ha, 36'hE_DCBA_9876);
    rd(8, 4'h0, "R8 read after write merges lanes");
    wr(8, 4'h0, 36'h7_7777_7777);
    idle(1);
    rd(8, 4'h0, "R8 read two after write");
    idle(2);
  endtask

  task automatic t_desel;
    rd(3, 4'h0, "R9 read before deselect");
    idle(3);
    chk("R9 bus idle after drain", dq, 36'bz);
    chk("R9 dvalid low after drain", {35'b0, dvalid}, 36'd0);
  endtask

  task automatic t_oe;
    rd(4, 4'h0, "R10 read with oe gated");
    idle(1);
    step(0, 0, 0, 4'hf, 0, '0, 0, "idle");
    idle(2);
  endtask

  task automatic t_adv;
    wr(15, 4'h0, 36'h0_F0F0_F0F0);
    step(1, 1, 1, 4'h0, 7, 36'h0_0A0A_0A0A, 1, "write");
    idle(2);
    rd(15, 4'h0, "R11 loaded address");
    step(1, 0, 1, 4'h0, 3, '0, 1, "R11 advanced address wraps");
    idle(2);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      h_v[i] = 0; h_w[i] = 0; h_a[i] = 0; h_m[i] = 0; h_d[i] = 0; h_t[i] = "";
    end
    for (int i = 0; i < DEPTH; i++) refm[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset;
    @(negedge clk);
    t_full;
    t_lanes;
    t_abort;
    t_mask;
    t_interleave;
    t_forward;
    t_desel;
    t_oe;
    t_adv;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(5 * 200000);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule